// File: doc/BRIEF.md
# Clock Stop and Power-Down Sequencer

This block sits between the internal clock sources of a clock synthesizer and its output buffers. It gates two groups of derived clocks from asynchronous active-low requests. One request parks the processor and memory group, which runs from the processor source clock. The other parks the system-bus group, which runs from a half-rate bus source clock. A free-running bus clock stops only for power-down. Every request is first brought into the processor clock domain through a flop chain. The gates then change their enables only while their source clock is low. As a result, a stopped clock always rests low and a restarted clock never emits a shortened high phase.

A third active-low request runs a power-down sequence. The sequence closes every gate, waits until the bus-domain gates have also closed, and only then drops the PLL and oscillator enables. When the request is released, both enables rise again. A settle counter, set by a parameter, stands in for oscillator and PLL lock time, and every output stays low until it expires. The same settle period follows reset. While power-down is in progress or in effect, the two stop requests have no effect.

Top module: `ckg_ctrl`

## Requirements
- R1: Reset brings every gated output low with `pll_en` and `osc_en` high. After reset is released, all gated outputs stay low for WAKE_CYCLES processor clock cycles. The first processor-group high phase then begins on rising edge WAKE_CYCLES+1.
- R2: Each of `cpu_stop_n`, `bus_stop_n` and `pwr_dn_n` passes through SYNC_STAGES (default 2) flops clocked by `clk_cpu_src` before it acts. With the default, an input changed just after rising edge k first acts on the output after rising edge k+2.
- R3: A stopped or powered-down clock rests at logic 0. Every high phase on a gated output lasts a full half-period of its source clock.
- R4: The processor and memory outputs (`cpu_clk`, `sdram_clk`) open and close together on the first falling edge of `clk_cpu_src` after their synchronized request changes, which is within one processor cycle.
- R5: The `bus_clk` outputs open and close on the first falling edge of `clk_bus_src` after their synchronized request changes. This is always fewer than 4 processor cycles.
- R6: A stop request on one group leaves the other group's clocks and `bus_free_clk` toggling at full rate. `bus_free_clk` stops only for power-down.
- R7: Power-down closes every gate first. Exactly 2 processor cycles after the synchronized request, it drives `pll_en` and `osc_en` low together, with every gated output already low.
- R8: While power-down is active, changes on `cpu_stop_n` and `bus_stop_n` leave every gated output low and both enables low.
- R9: After the synchronized release of power-down, `pll_en` and `osc_en` rise one processor cycle later. The outputs stay low for a further WAKE_CYCLES cycles, and the processor group resumes on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu_src | input | 1 | Processor-rate source clock; also clocks the synchronizers and sequencer |
| clk_bus_src | input | 1 | Half-rate bus source clock, edges aligned to falling edges of clk_cpu_src |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Asynchronous active-low stop request for the processor/memory group |
| bus_stop_n | input | 1 | Asynchronous active-low stop request for the bus group |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down request |
| cpu_clk | output | N_CPU | Gated processor clocks |
| sdram_clk | output | N_SDRAM | Gated memory clocks, same enable as cpu_clk |
| bus_clk | output | N_BUS | Gated bus clocks |
| bus_free_clk | output | 1 | Bus clock that stops only for power-down |
| pll_en | output | 1 | PLL enable, low while powered down |
| osc_en | output | 1 | Oscillator enable, low while powered down |

## Verification
Every stimulus is applied one nanosecond after a processor rising edge. Each result is then read from pulse counts taken over a window of whole processor cycles. Processor-group pulses are due from edge 3 after a release and end after edge 2 after a stop, so windows of ten cycles expect exact counts of 8 and 2. A bus-group change lands on one of two possible bus falling edges, depending on bus phase, so those windows accept a two-value range. The enable outputs are sampled at fixed edges: two edges after the synchronized power-down request, and one edge after the synchronized release.

// File: rtl/ckg_pkg.sv
`timescale 1ns/1ps
package ckg_pkg;

  typedef enum logic [1:0] {
    PS_WAKE = 2'd0,
    PS_RUN  = 2'd1,
    PS_PARK = 2'd2,
    PS_OFF  = 2'd3
  } pwr_state_e;

  // Clocks may flow only in the run state and only while no power-down is pending.
  function automatic logic clocks_allowed(input pwr_state_e s, input logic pd_req);
    return (s == PS_RUN) && !pd_req;
  endfunction

  // The analog rails are enabled in every state except the fully-off one.
  function automatic logic rails_on(input pwr_state_e s);
    return s != PS_OFF;
  endfunction

  // A group gate opens when clocks are allowed and its own request is released.
  function automatic logic group_go(input logic allowed, input logic released);
    return allowed & released;
  endfunction

  // Width of a down-counter able to hold the larger of two cycle counts.
  function automatic int unsigned count_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/ckg_sync.sv
`timescale 1ns/1ps
module ckg_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RESET_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ckg_gate.sv
`timescale 1ns/1ps
module ckg_gate #(
  parameter int unsigned FANOUT = 1
) (
  input  logic              clk_src,
  input  logic              rst_n,
  input  logic              en_req,
  output logic              en_q,
  output logic [FANOUT-1:0] clk_out
);

  // Enable is captured on the falling edge, so it only moves while clk_src is low.
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_req;
  end

  assign clk_out = {FANOUT{clk_src & en_q}};

endmodule

// File: rtl/ckg_pwr_seq.sv
`timescale 1ns/1ps
module ckg_pwr_seq
  import ckg_pkg::*;
#(
  parameter int unsigned WAKE_CYCLES = 16,
  parameter int unsigned PARK_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  output logic run_ok,
  output logic pll_en,
  output logic osc_en
);

  localparam int unsigned CW = count_width(WAKE_CYCLES, PARK_CYCLES);
  localparam logic [CW-1:0] WAKE_LOAD = CW'(WAKE_CYCLES - 1);
  localparam logic [CW-1:0] PARK_LOAD = CW'(PARK_CYCLES - 1);

  pwr_state_e    state;
  logic [CW-1:0] cnt;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PS_WAKE;
      cnt   <= WAKE_LOAD;
    end else begin
      unique case (state)
        PS_WAKE: begin
          if (pd_req)        state <= PS_OFF;
          else if (cnt_zero) state <= PS_RUN;
          else               cnt   <= cnt - 1'b1;
        end
        PS_RUN: begin
          if (pd_req) begin
            state <= PS_PARK;
            cnt   <= PARK_LOAD;
          end
        end
        PS_PARK: begin
          if (cnt_zero) state <= PS_OFF;
          else          cnt   <= cnt - 1'b1;
        end
        PS_OFF: begin
          if (!pd_req) begin
            state <= PS_WAKE;
            cnt   <= WAKE_LOAD;
          end
        end
        default: state <= PS_OFF;
      endcase
    end
  end

  assign run_ok = clocks_allowed(state, pd_req);
  assign pll_en = rails_on(state);
  assign osc_en = rails_on(state);

endmodule

// File: rtl/ckg_ctrl.sv
`timescale 1ns/1ps
module ckg_ctrl
  import ckg_pkg::*;
#(
  parameter int unsigned N_CPU       = 4,
  parameter int unsigned N_SDRAM     = 6,
  parameter int unsigned N_BUS       = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WAKE_CYCLES = 16,
  parameter int unsigned PARK_CYCLES = 1
) (
  input  logic               clk_cpu_src,
  input  logic               clk_bus_src,
  input  logic               rst_n,
  input  logic               cpu_stop_n,
  input  logic               bus_stop_n,
  input  logic               pwr_dn_n,
  output logic [N_CPU-1:0]   cpu_clk,
  output logic [N_SDRAM-1:0] sdram_clk,
  output logic [N_BUS-1:0]   bus_clk,
  output logic               bus_free_clk,
  output logic               pll_en,
  output logic               osc_en
);

  localparam int unsigned N_CORE = N_CPU + N_SDRAM;

  // Synchronized request levels (1 = released / powered up).
  logic cpu_go_s;
  logic bus_go_s;
  logic pwr_up_s;

  // Named internal events brought out for the checker.
  logic run_ok;
  logic cpu_run_req;
  logic bus_run_req;
  logic free_run_req;
  logic cpu_en_q;
  logic bus_en_q;
  logic free_en_q;

  logic [N_CORE-1:0] core_clk;
  logic [0:0]        free_clk;

  ckg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_cpu (
    .clk(clk_cpu_src), .rst_n(rst_n), .d(cpu_stop_n), .q(cpu_go_s)
  );
  ckg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_bus (
    .clk(clk_cpu_src), .rst_n(rst_n), .d(bus_stop_n), .q(bus_go_s)
  );
  ckg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_pwr (
    .clk(clk_cpu_src), .rst_n(rst_n), .d(pwr_dn_n), .q(pwr_up_s)
  );

  ckg_pwr_seq #(.WAKE_CYCLES(WAKE_CYCLES), .PARK_CYCLES(PARK_CYCLES)) u_seq (
    .clk    (clk_cpu_src),
    .rst_n  (rst_n),
    .pd_req (!pwr_up_s),
    .run_ok (run_ok),
    .pll_en (pll_en),
    .osc_en (osc_en)
  );

  assign cpu_run_req  = group_go(run_ok, cpu_go_s);
  assign bus_run_req  = group_go(run_ok, bus_go_s);
  assign free_run_req = group_go(run_ok, 1'b1);

  ckg_gate #(.FANOUT(N_CORE)) u_gate_core (
    .clk_src(clk_cpu_src), .rst_n(rst_n), .en_req(cpu_run_req),
    .en_q(cpu_en_q), .clk_out(core_clk)
  );
  ckg_gate #(.FANOUT(N_BUS)) u_gate_bus (
    .clk_src(clk_bus_src), .rst_n(rst_n), .en_req(bus_run_req),
    .en_q(bus_en_q), .clk_out(bus_clk)
  );
  ckg_gate #(.FANOUT(1)) u_gate_free (
    .clk_src(clk_bus_src), .rst_n(rst_n), .en_req(free_run_req),
    .en_q(free_en_q), .clk_out(free_clk)
  );

  assign cpu_clk      = core_clk[N_CPU-1:0];
  assign sdram_clk    = core_clk[N_CORE-1:N_CPU];
  assign bus_free_clk = free_clk[0];

endmodule

// File: rtl/ckg_ctrl_checker.sv
`timescale 1ns/1ps
module ckg_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic pll_en,
  input logic cpu_run_req,
  input logic cpu_en_q,
  input logic bus_run_req,
  input logic bus_en_q,
  input logic free_en_q
);

  logic [2:0] bus_lag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      bus_lag <= '0;
    else if (bus_en_q == bus_run_req) bus_lag <= '0;
    else if (bus_lag != 3'd7)         bus_lag <= bus_lag + 1'b1;
  end

  // R4: the falling-edge enable has caught up with the request by every rising edge.
  a_r4_core_gate_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en_q == cpu_run_req);

  // R5: the bus enable never trails its request for 4 or more processor cycles.
  a_r5_bus_lag_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lag < 3'd4);

  // R7: the rails drop only after every gate has closed.
  a_r7_gates_closed_before_rails: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_en) |-> (!cpu_en_q && !bus_en_q && !free_en_q));

  // R8: no gate opens while the rails are off.
  a_r8_off_keeps_gates_shut: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |-> (!cpu_en_q && !bus_en_q && !free_en_q));

  // R9: the gates stay shut on the cycle after the rails come back.
  a_r9_settle_before_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |=> !cpu_en_q);

endmodule

bind ckg_ctrl ckg_ctrl_checker u_chk (
  .clk         (clk_cpu_src),
  .rst_n       (rst_n),
  .pll_en      (pll_en),
  .cpu_run_req (cpu_run_req),
  .cpu_en_q    (cpu_en_q),
  .bus_run_req (bus_run_req),
  .bus_en_q    (bus_en_q),
  .free_en_q   (free_en_q)
);

// File: tb/ckg_ctrl_bench.sv
`timescale 1ns/1ps
module ckg_ctrl_bench;

  localparam int N_CPU = 4;
  localparam int N_SDRAM = 6;
  localparam int N_BUS = 6;
  localparam int W = 16;

  logic clk_cpu_src = 1'b0;
  logic clk_bus_src = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_stop_n = 1'b1;
  logic bus_stop_n = 1'b1;
  logic pwr_dn_n = 1'b1;
  logic [N_CPU-1:0]   cpu_clk;
  logic [N_SDRAM-1:0] sdram_clk;
  logic [N_BUS-1:0]   bus_clk;
  logic bus_free_clk;
  logic pll_en;
  logic osc_en;

  ckg_ctrl #(.N_CPU(N_CPU), .N_SDRAM(N_SDRAM), .N_BUS(N_BUS),
             .SYNC_STAGES(2), .WAKE_CYCLES(W), .PARK_CYCLES(1)) u_ckg_ctrl (
    .clk_cpu_src(clk_cpu_src), .clk_bus_src(clk_bus_src), .rst_n(rst_n),
    .cpu_stop_n(cpu_stop_n), .bus_stop_n(bus_stop_n), .pwr_dn_n(pwr_dn_n),
    .cpu_clk(cpu_clk), .sdram_clk(sdram_clk), .bus_clk(bus_clk),
    .bus_free_clk(bus_free_clk), .pll_en(pll_en), .osc_en(osc_en)
  );

  // 250 MHz processor source; bus source at half rate, edges on processor falling edges.
  always #2 clk_cpu_src = ~clk_cpu_src;
  initial begin
    #4;
    forever #4 clk_bus_src = ~clk_bus_src;
  end

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Pulse counters and runt monitor.
  int n_cpu, n_sdram, n_bus, n_free;
  int runts = 0;
  realtime t_cpu, t_bus, t_free;

  always @(posedge cpu_clk[0])          n_cpu++;
  always @(posedge sdram_clk[N_SDRAM-1]) n_sdram++;
  always @(posedge bus_clk[0])          n_bus++;
  always @(posedge bus_free_clk)        n_free++;

  always @(posedge cpu_clk[0])   t_cpu = $realtime;
  always @(negedge cpu_clk[0])   if ($realtime - t_cpu < 1.9) runts++;
  always @(posedge bus_clk[0])   t_bus = $realtime;
  always @(negedge bus_clk[0])   if ($realtime - t_bus < 3.9) runts++;
  always @(posedge bus_free_clk) t_free = $realtime;
  always @(negedge bus_free_clk) if ($realtime - t_free < 3.9) runts++;

  // Scoreboard: driver pushes expectations and observations, monitor compares.
  typedef struct {
    string tag;
    int    lo;
    int    hi;
  } exp_t;
  exp_t exp_q[$];
  int   act_q[$];

  task automatic expect_range(input string tag, input int act, input int lo, input int hi);
    exp_t e;
    e.tag = tag; e.lo = lo; e.hi = hi;
    exp_q.push_back(e);
    act_q.push_back(act);
  endtask

  initial begin
    forever begin
      exp_t e;
      int a;
      wait (act_q.size() > 0);
      e = exp_q.pop_front();
      a = act_q.pop_front();
      total++;
      if (a < e.lo || a > e.hi) begin
        bad++;
        if (e.lo == e.hi)
          $display("FAIL %s: actual=%0d expected=%0d", e.tag, a, e.lo);
        else
          $display("FAIL %s: actual=%0d expected=%0d..%0d", e.tag, a, e.lo, e.hi);
      end
    end
  end

  task automatic window(input int n);
    n_cpu = 0; n_sdram = 0; n_bus = 0; n_free = 0;
    repeat (n) @(posedge clk_cpu_src);
    #1;
  endtask

  task automatic edge_plus1();
    @(posedge clk_cpu_src);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #800000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk_cpu_src);
    #1;
    expect_range("R1 reset cpu_clk level", int'(cpu_clk), 0, 0);
    expect_range("R1 reset bus_clk level", int'(bus_clk), 0, 0);
    expect_range("R1 reset pll_en", int'(pll_en), 1, 1);
    expect_range("R1 reset osc_en", int'(osc_en), 1, 1);
    rst_n = 1'b1;
    window(W);
    expect_range("R1 settle cpu pulses", n_cpu, 0, 0);
    expect_range("R1 settle free pulses", n_free, 0, 0);
    window(6);
    expect_range("R1 first cpu pulses", n_cpu, 6, 6);
    expect_range("R1 first sdram pulses", n_sdram, 6, 6);
    window(10);

    // R4/R2: processor group stop; R6: bus clocks undisturbed
    cpu_stop_n = 1'b0;
    window(10);
    expect_range("R4 R2 cpu pulses after stop", n_cpu, 2, 2);
    expect_range("R4 sdram pulses after stop", n_sdram, 2, 2);
    expect_range("R6 bus pulses during cpu stop", n_bus, 5, 5);
    expect_range("R6 free pulses during cpu stop", n_free, 5, 5);
    window(10);
    expect_range("R3 cpu parked pulses", n_cpu, 0, 0);
    expect_range("R3 cpu parked level", int'(cpu_clk), 0, 0);
    expect_range("R3 sdram parked level", int'(sdram_clk), 0, 0);
    cpu_stop_n = 1'b1;
    window(10);
    expect_range("R4 R2 cpu pulses after release", n_cpu, 8, 8);
    expect_range("R4 sdram pulses after release", n_sdram, 8, 8);

    // R5: bus group stop; R6: processor group and free bus clock undisturbed
    edge_plus1();
    bus_stop_n = 1'b0;
    window(10);
    expect_range("R5 bus pulses after stop", n_bus, 1, 2);
    expect_range("R6 cpu pulses during bus stop", n_cpu, 10, 10);
    expect_range("R6 free pulses during bus stop", n_free, 5, 5);
    window(10);
    expect_range("R3 bus parked pulses", n_bus, 0, 0);
    expect_range("R3 bus parked level", int'(bus_clk), 0, 0);
    expect_range("R6 free keeps running", n_free, 5, 5);
    bus_stop_n = 1'b1;
    window(10);
    expect_range("R5 bus pulses after release", n_bus, 3, 4);
    window(10);

    // R7: power-down
    pwr_dn_n = 1'b0;
    window(3);
    expect_range("R7 cpu pulses before park", n_cpu, 2, 2);
    expect_range("R7 pll_en still on", int'(pll_en), 1, 1);
    window(1);
    expect_range("R7 pll_en off", int'(pll_en), 0, 0);
    expect_range("R7 osc_en off", int'(osc_en), 0, 0);
    expect_range("R7 bus level at rails off", int'(bus_clk), 0, 0);
    window(10);
    expect_range("R7 cpu pulses while off", n_cpu, 0, 0);
    expect_range("R7 free pulses while off", n_free, 0, 0);

    // R8: stop requests ignored while powered down
    cpu_stop_n = 1'b0;
    bus_stop_n = 1'b0;
    window(5);
    cpu_stop_n = 1'b1;
    window(5);
    bus_stop_n = 1'b1;
    window(10);
    expect_range("R8 cpu pulses after stop toggles", n_cpu, 0, 0);
    expect_range("R8 bus pulses after stop toggles", n_bus, 0, 0);
    expect_range("R8 free pulses after stop toggles", n_free, 0, 0);
    expect_range("R8 pll_en stays off", int'(pll_en), 0, 0);

    // R9: wake-up
    pwr_dn_n = 1'b1;
    window(2);
    expect_range("R9 pll_en before sync", int'(pll_en), 0, 0);
    window(1);
    expect_range("R9 pll_en back on", int'(pll_en), 1, 1);
    expect_range("R9 osc_en back on", int'(osc_en), 1, 1);
    window(W);
    expect_range("R9 settle cpu pulses", n_cpu, 0, 0);
    expect_range("R9 settle bus pulses", n_bus, 0, 0);
    window(6);
    expect_range("R9 resumed cpu pulses", n_cpu, 6, 6);
    window(10);
    expect_range("R9 resumed free pulses", n_free, 5, 5);

    // R3: no shortened high phase anywhere in the run
    expect_range("R3 runt pulses", runts, 0, 0);

    wait (act_q.size() == 0);
    #1;
    finish_run();
  end

endmodule